// File: doc/BRIEF.md
# Serial Control Word Loader

This block takes configuration words for a two-loop frequency synthesizer from a three-wire serial port. The port has a serial clock, a data line and a load strobe. The block samples all three pins, and two run pins, into its own system clock domain. On each rising edge of the serial clock it shifts the data bit into a 22-bit frame register, most significant bit first. When the load strobe rises, the two bits shifted in last pick one of three destinations: the reference divide ratio, the loop 1 divide value or the loop 2 divide value. The payload is copied into the chosen holding register, and a one-cycle update strobe is raised for that register.

A reference word also carries three enable flags, named A, B and C. Each loop's power-on output is the AND of its run pin and its enable flag. A low run pin always powers that loop down. Flag C is stored with the word but does not affect the power outputs.

A small state machine controls the transfer:
- `ST_SHIFT` accepts serial bits. Transition `T_ARM` is a detected rise of the load strobe, and it leads to `ST_COMMIT`.
- `ST_COMMIT` lasts exactly one cycle and performs the transfer. Transition `T_DONE` leads unconditionally to `ST_WAIT_LOW`.
- `ST_WAIT_LOW` holds while the load strobe stays high. Transition `T_REARM`, taken when the strobe returns low, leads back to `ST_SHIFT`.

Serial clock edges are ignored outside `ST_SHIFT`.

Top module: `cw_loader`

## Requirements
- R1: While and after reset, all three holding registers read zero, both power outputs are low and no update strobe is high.
- R2: Each rising edge of `ser_clk` shifts `ser_dat` into the frame, so the bit shifted last before `ser_le` rises is frame bit 0. Only the last 22 bits are kept; earlier bits are discarded.
- R3: A frame with bits [1:0] = 2'b01 loads bits [18:2] into `l1_div`. `upd_l1` is then high for exactly one cycle, after the 4th rising `clk` edge following the rise of `ser_le`.
- R4: A frame with bits [1:0] = 2'b10 loads bits [18:2] into `l2_div`, and `upd_l2` is raised with the same timing as R3.
- R5: A frame with bits [1:0] = 2'b11 and an 11-bit ratio in bits [12:2] between 5 and 2047 loads that ratio into `ref_ratio` and raises `upd_ref` with the timing of R3. The same load stores flag A from bit 13, flag B from bit 14 and flag C from bit 15.
- R6: A frame with bits [1:0] = 2'b00 changes no holding register, no flag and no power output, and raises no strobe.
- R7: A reference frame whose ratio is below 5 is rejected. No register or flag changes and no strobe is raised.
- R8: One rise of `ser_le` causes at most one transfer, however long the strobe is held high.
- R9: With both run pins high, `pwr1` equals flag A and `pwr2` equals flag B. Flag C has no effect.
- R10: A low level on `run1` (or `run2`) forces `pwr1` (or `pwr2`) low, whatever the flags say.
- R11: At most one update strobe is high in any cycle, and a holding register changes only in a cycle when its own strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load strobe; a rising edge transfers the frame |
| run1 | input | 1 | Loop 1 run pin, high means run |
| run2 | input | 1 | Loop 2 run pin, high means run |
| ref_ratio | output | 11 | Reference divide ratio register |
| l1_div | output | 17 | Loop 1 divide value register |
| l2_div | output | 17 | Loop 2 divide value register |
| upd_ref | output | 1 | One-cycle update strobe for `ref_ratio` |
| upd_l1 | output | 1 | One-cycle update strobe for `l1_div` |
| upd_l2 | output | 1 | One-cycle update strobe for `l2_div` |
| pwr1 | output | 1 | Loop 1 power-on |
| pwr2 | output | 1 | Loop 2 power-on |

## Verification
Counting from the rising `clk` edge after an `ser_le` rise, the update strobe and the new register value appear after the 4th edge: two synchronizer stages, one edge to enter `ST_COMMIT` and one edge to transfer. The power outputs follow a load one edge later. They follow a run pin change after the 3rd edge. The bench drives every pin on a falling edge and samples on falling edges. During each load it expects the strobe vector to be zero in every sampled cycle except the 4th, and holds `ser_le` long enough to show that no second strobe follows. For run pins it checks that the power output is still unchanged after the 2nd edge and has changed after the 3rd. Serial bits are held stable for several cycles around each `ser_clk` rise, so synchronizer latency cannot move a bit into the wrong position.

// File: rtl/cwl_pkg.sv
package cwl_pkg;

    // Transfer controller states
    typedef enum logic [1:0] {
        ST_SHIFT    = 2'd0,
        ST_COMMIT   = 2'd1,
        ST_WAIT_LOW = 2'd2
    } ld_state_e;

    // Destination select field, the last two bits shifted in
    localparam int SEL_W = 2;
    typedef logic [SEL_W-1:0] sel_t;

    localparam sel_t SEL_NONE  = 2'b00;
    localparam sel_t SEL_LOOP1 = 2'b01;
    localparam sel_t SEL_LOOP2 = 2'b10;
    localparam sel_t SEL_REF   = 2'b11;

endpackage

// File: rtl/cwl_sync.sv
module cwl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/cwl_frame.sv
module cwl_frame
    import cwl_pkg::*;
#(
    parameter int FRAME_W = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               sdi_s,
    input  logic               le_s,
    output logic [FRAME_W-1:0] frame,
    output logic               commit
);

    ld_state_e state, state_nx;
    logic      sck_q, le_q;
    logic      sck_rise, le_rise;

    // Previous-cycle copies for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            le_q  <= 1'b0;
        end else begin
            sck_q <= sck_s;
            le_q  <= le_s;
        end
    end

    assign sck_rise = sck_s & ~sck_q;
    assign le_rise  = le_s & ~le_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SHIFT;
        else        state <= state_nx;
    end

    // Transitions: T_ARM, T_DONE, T_REARM
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SHIFT:    if (le_rise) state_nx = ST_COMMIT;
            ST_COMMIT:   state_nx = ST_WAIT_LOW;
            ST_WAIT_LOW: if (!le_s) state_nx = ST_SHIFT;
            default:     state_nx = ST_SHIFT;
        endcase
    end

    // Frame shifter, active only while accepting bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame <= '0;
        end else if (state == ST_SHIFT && sck_rise && !le_s) begin
            frame <= {frame[FRAME_W-2:0], sdi_s};
        end
    end

    assign commit = (state == ST_COMMIT);

endmodule

// File: rtl/cwl_route.sv
module cwl_route
    import cwl_pkg::*;
#(
    parameter int FRAME_W = 22,
    parameter int REF_W   = 11,
    parameter int DIV_W   = 17,
    parameter int REF_MIN = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [FRAME_W-1:0] frame,
    output logic [REF_W-1:0]   ref_ratio,
    output logic [DIV_W-1:0]   l1_div,
    output logic [DIV_W-1:0]   l2_div,
    output logic               flag_a,
    output logic               flag_b,
    output logic               flag_c,
    output logic               upd_ref,
    output logic               upd_l1,
    output logic               upd_l2
);

    localparam int PAY_LSB  = SEL_W;
    localparam int FLAG_LSB = PAY_LSB + REF_W;

    sel_t             sel;
    logic [REF_W-1:0] ratio_in;
    logic [DIV_W-1:0] div_in;
    logic             ref_ok;
    logic             unused_frame;

    assign sel          = frame[SEL_W-1:0];
    assign ratio_in     = frame[PAY_LSB +: REF_W];
    assign div_in       = frame[PAY_LSB +: DIV_W];
    assign ref_ok       = (ratio_in >= REF_W'(REF_MIN));
    assign unused_frame = ^frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_ratio <= '0;
            l1_div    <= '0;
            l2_div    <= '0;
            flag_a    <= 1'b0;
            flag_b    <= 1'b0;
            flag_c    <= 1'b0;
            upd_ref   <= 1'b0;
            upd_l1    <= 1'b0;
            upd_l2    <= 1'b0;
        end else begin
            upd_ref <= 1'b0;
            upd_l1  <= 1'b0;
            upd_l2  <= 1'b0;
            if (commit) begin
                case (sel)
                    SEL_LOOP1: begin
                        l1_div <= div_in;
                        upd_l1 <= 1'b1;
                    end
                    SEL_LOOP2: begin
                        l2_div <= div_in;
                        upd_l2 <= 1'b1;
                    end
                    SEL_REF: begin
                        if (ref_ok) begin
                            ref_ratio <= ratio_in;
                            flag_a    <= frame[FLAG_LSB];
                            flag_b    <= frame[FLAG_LSB+1];
                            flag_c    <= frame[FLAG_LSB+2];
                            upd_ref   <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cwl_power.sv
module cwl_power #(
    parameter int N_LOOPS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LOOPS-1:0] run_s,
    input  logic [N_LOOPS-1:0] en,
    output logic [N_LOOPS-1:0] pwr
);

    // A low run pin overrides the enable flag of its loop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr <= '0;
        else        pwr <= run_s & en;
    end

endmodule

// File: rtl/cw_loader.sv
module cw_loader #(
    parameter int FRAME_W     = 22,
    parameter int REF_W       = 11,
    parameter int DIV_W       = 17,
    parameter int REF_MIN     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_le,
    input  logic             run1,
    input  logic             run2,
    output logic [REF_W-1:0] ref_ratio,
    output logic [DIV_W-1:0] l1_div,
    output logic [DIV_W-1:0] l2_div,
    output logic             upd_ref,
    output logic             upd_l1,
    output logic             upd_l2,
    output logic             pwr1,
    output logic             pwr2
);

    localparam int N_PINS  = 5;
    localparam int N_LOOPS = 2;

    logic [N_PINS-1:0]  pins_s;
    logic [N_LOOPS-1:0] run_s;
    logic [N_LOOPS-1:0] pwr;
    logic [FRAME_W-1:0] frame;
    logic               commit;
    logic               flag_a, flag_b, flag_c;
    logic               unused_flag;

    cwl_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({run2, run1, ser_le, ser_dat, ser_clk}),
        .q     (pins_s)
    );

    assign run_s = pins_s[4:3];

    cwl_frame #(.FRAME_W(FRAME_W)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s  (pins_s[0]),
        .sdi_s  (pins_s[1]),
        .le_s   (pins_s[2]),
        .frame  (frame),
        .commit (commit)
    );

    cwl_route #(
        .FRAME_W (FRAME_W),
        .REF_W   (REF_W),
        .DIV_W   (DIV_W),
        .REF_MIN (REF_MIN)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .frame     (frame),
        .ref_ratio (ref_ratio),
        .l1_div    (l1_div),
        .l2_div    (l2_div),
        .flag_a    (flag_a),
        .flag_b    (flag_b),
        .flag_c    (flag_c),
        .upd_ref   (upd_ref),
        .upd_l1    (upd_l1),
        .upd_l2    (upd_l2)
    );

    // Flag C is held but steers nothing
    assign unused_flag = flag_c;

    cwl_power #(.N_LOOPS(N_LOOPS)) u_power (
        .clk   (clk),
        .rst_n (rst_n),
        .run_s (run_s),
        .en    ({flag_b, flag_a}),
        .pwr   (pwr)
    );

    assign pwr1 = pwr[0];
    assign pwr2 = pwr[1];

endmodule

// File: rtl/cw_loader_chk.sv
module cw_loader_chk #(
    parameter int REF_W   = 11,
    parameter int DIV_W   = 17,
    parameter int REF_MIN = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REF_W-1:0] ref_ratio,
    input logic [DIV_W-1:0] l1_div,
    input logic [DIV_W-1:0] l2_div,
    input logic             upd_ref,
    input logic             upd_l1,
    input logic             upd_l2,
    input logic [1:0]       run_s,
    input logic             pwr1,
    input logic             pwr2
);

    p_onehot_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({upd_ref, upd_l1, upd_l2}));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ref || upd_l1 || upd_l2) |=> !(upd_ref || upd_l1 || upd_l2));

    p_l1_only_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(l1_div) |-> upd_l1);

    p_l2_only_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(l2_div) |-> upd_l2);

    p_ref_only_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_ratio) |-> upd_ref);

    p_ref_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ref |-> (ref_ratio >= REF_W'(REF_MIN)));

    p_sleep1_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_s[0] |=> !pwr1);

    p_sleep2_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_s[1] |=> !pwr2);

endmodule

bind cw_loader cw_loader_chk #(
    .REF_W   (REF_W),
    .DIV_W   (DIV_W),
    .REF_MIN (REF_MIN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_ratio (ref_ratio),
    .l1_div    (l1_div),
    .l2_div    (l2_div),
    .upd_ref   (upd_ref),
    .upd_l1    (upd_l1),
    .upd_l2    (upd_l2),
    .run_s     (run_s),
    .pwr1      (pwr1),
    .pwr2      (pwr2)
);

// File: tb/cw_loader_tb_top.sv
module cw_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic        run1 = 1'b0, run2 = 1'b0;
    logic [10:0] ref_ratio;
    logic [16:0] l1_div, l2_div;
    logic        upd_ref, upd_l1, upd_l2, pwr1, pwr2;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cw_loader dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_le(ser_le), .run1(run1), .run2(run2), .ref_ratio(ref_ratio),
        .l1_div(l1_div), .l2_div(l2_div), .upd_ref(upd_ref), .upd_l1(upd_l1),
        .upd_l2(upd_l2), .pwr1(pwr1), .pwr2(pwr2)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) ser_dat = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    // Strobe vector bit0 = l1, bit1 = l2, bit2 = ref; due after the 4th edge
    task automatic do_load(input logic [2:0] exp, input int hold, input string tag);
        @(negedge clk) ser_le = 1'b1;
        for (int i = 1; i <= hold; i++) begin
            @(negedge clk);
            chk(tag, {upd_ref, upd_l2, upd_l1}, (i == 4) ? exp : 3'b000);
        end
        ser_le = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [21:0] loop_word(input logic [16:0] v, input logic [1:0] sel);
        return {3'b000, v, sel};
    endfunction

    function automatic logic [21:0] ref_word(input logic [10:0] r, input logic a, b, c);
        return {6'b0, c, b, a, r, 2'b11};
    endfunction

    task automatic t_reset;
        chk("R1 ref_ratio at reset", ref_ratio, 0);
        chk("R1 l1_div at reset", l1_div, 0);
        chk("R1 l2_div at reset", l2_div, 0);
        chk("R1 strobes at reset", {upd_ref, upd_l2, upd_l1}, 0);
        chk("R1 power at reset", {pwr2, pwr1}, 0);
    endtask

    task automatic t_loop1;
        send_bits(32'h003F_FFFF, 22);              // stale bits that must fall out
        send_bits(loop_word(17'h1ABCD, 2'b01), 22);
        do_load(3'b001, 6, "R3 loop1 strobe timing");
        chk("R3 l1_div value", l1_div, 17'h1ABCD);
        chk("R2 stale bits discarded, ref untouched", ref_ratio, 0);
        chk("R2 l2_div untouched", l2_div, 0);
    endtask

    task automatic t_loop2;
        send_bits(32'h7, 3);                       // leading extra bits
        send_bits(loop_word(17'h0F0F3, 2'b10), 22);
        do_load(3'b010, 6, "R4 loop2 strobe timing");
        chk("R4 l2_div value", l2_div, 17'h0F0F3);
        chk("R4 l1_div kept", l1_div, 17'h1ABCD);
    endtask

    task automatic t_ref_flags;
        send_bits(ref_word(11'd1250, 1'b1, 1'b0, 1'b1), 22);
        do_load(3'b100, 6, "R5 ref strobe timing");
        chk("R5 ref_ratio value", ref_ratio, 1250);
        chk("R9 pwr A=1 B=0 C=1", {pwr2, pwr1}, 2'b01);
        send_bits(ref_word(11'd1250, 1'b1, 1'b0, 1'b0), 22);
        do_load(3'b100, 6, "R5 ref reload strobe");
        chk("R9 C has no effect", {pwr2, pwr1}, 2'b01);
        send_bits(ref_word(11'd2047, 1'b0, 1'b1, 1'b1), 22);
        do_load(3'b100, 6, "R5 ref max strobe");
        chk("R5 ref_ratio 2047", ref_ratio, 2047);
        chk("R9 pwr A=0 B=1", {pwr2, pwr1}, 2'b10);
    endtask

    task automatic t_unused;
        send_bits({3'b000, 17'h15555, 2'b00}, 22);
        do_load(3'b000, 8, "R6 unused code strobe");
        chk("R6 l1_div kept", l1_div, 17'h1ABCD);
        chk("R6 l2_div kept", l2_div, 17'h0F0F3);
        chk("R6 ref_ratio kept", ref_ratio, 2047);
        chk("R6 power kept", {pwr2, pwr1}, 2'b10);
    endtask

    task automatic t_floor;
        send_bits(ref_word(11'd4, 1'b1, 1'b1, 1'b0), 22);
        do_load(3'b000, 8, "R7 ratio 4 rejected strobe");
        chk("R7 ref_ratio kept", ref_ratio, 2047);
        chk("R7 flags kept", {pwr2, pwr1}, 2'b10);
        send_bits(ref_word(11'd5, 1'b1, 1'b1, 1'b0), 22);
        do_load(3'b100, 6, "R5 ratio 5 accepted strobe");
        chk("R5 ref_ratio 5", ref_ratio, 5);
        chk("R9 both enabled", {pwr2, pwr1}, 2'b11);
    endtask

    task automatic t_long_hold;
        send_bits(loop_word(17'h00042, 2'b01), 22);
        do_load(3'b001, 24, "R8 single transfer on long hold");
        chk("R8 l1_div value", l1_div, 17'h00042);
    endtask

    task automatic t_sleep;
        @(negedge clk) run1 = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 pwr1 before 3rd edge", pwr1, 1);
        @(negedge clk);
        chk("R10 run1 low forces pwr1 off", pwr1, 0);
        chk("R10 pwr2 unaffected", pwr2, 1);
        @(negedge clk) run1 = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 pwr1 back on", pwr1, 1);
        @(negedge clk) run2 = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 run2 low forces pwr2 off", {pwr2, pwr1}, 2'b01);
        @(negedge clk) run2 = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 pwr2 back on", pwr2, 1);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk) begin run1 = 1'b1; run2 = 1'b1; end
        repeat (4) @(negedge clk);
        chk("R1 power off before any load", {pwr2, pwr1}, 0);
        t_loop1;
        t_loop2;
        t_ref_flags;
        t_unused;
        t_floor;
        t_long_hold;
        t_sleep;
        done = 1'b1;
        finish_run;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run;
        end
    end

endmodule